// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry Out

This block shifts a 32-bit operand by an amount taken from a 32-bit register and returns both the shifted value and the carry flag the shift produces. Four operations are selected by a 2-bit code: logical left, logical right, arithmetic right and rotate right. Only the low byte of the amount register counts, so amounts from 0 to 255 are possible. Amounts at or beyond the data width give fixed results and carries rather than wrapping.

An amount of zero is a pass-through. The operand comes out untouched and the incoming carry is returned as the new carry. Inputs are qualified by a valid strobe. The result, the carry and an output strobe are registered one cycle later. When no strobe arrives, the output registers keep their last values.

Top module: `reg_shift_carry`

## Requirements
- R1: Only bits [7:0] of `amount_i` set the shift amount n. Bits [31:8] have no effect on the result or the carry.
- R2: When n = 0, for every operation, `result_o` equals the operand and `carry_o` equals `carry_i`.
- R3: Logical left (op 2'b00):
  - For n in 1..31, the result is the operand shifted left by n and the carry is operand bit (32 - n).
  - For n = 32, the result is 0 and the carry is operand bit 0.
  - For n > 32, the result is 0 and the carry is 0.
- R4: Logical right (op 2'b01):
  - For n in 1..31, the result is the operand shifted right by n with zero fill and the carry is operand bit (n - 1).
  - For n = 32, the result is 0 and the carry is operand bit 31.
  - For n > 32, the result is 0 and the carry is 0.
- R5: Arithmetic right (op 2'b10):
  - For n in 1..31, the result is the operand shifted right by n with sign fill and the carry is operand bit (n - 1).
  - For n >= 32, every result bit equals operand bit 31 and the carry is operand bit 31.
- R6: Rotate right (op 2'b11), with r = n mod 32:
  - For r != 0, the result is the operand rotated right by r and the carry is operand bit (r - 1).
  - For r = 0 with n != 0, the result equals the operand and the carry is operand bit 31.
- R7: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high. The result and carry for those inputs appear in that same cycle.
- R8: While `valid_i` is low, `result_o` and `carry_o` keep their values.
- R9: After reset, `valid_o`, `carry_o` and `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe |
| op_i | input | 2 | Operation: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| operand_i | input | 32 | Value to shift |
| amount_i | input | 32 | Amount register; only the low byte is used |
| carry_i | input | 1 | Incoming carry, returned when the amount is zero |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Carry produced by the shift |
| valid_o | output | 1 | Output strobe, one cycle after valid_i |

## Verification
The hardest cases to reach are the boundaries where the carry comes from an unusual place:
- a left or logical right shift by exactly 32, which still yields a carry;
- a shift just past 32, where the carry drops to zero;
- a rotate by a nonzero multiple of 32, which leaves the value intact but replaces the carry with bit 31.

The stimulus table sets these amounts directly, including 64 and 200. It places junk in the upper 24 amount bits so that any leak of those bits would change the low-byte decode. A zero low byte combined with a nonzero upper part shows whether the pass-through depends only on the low byte.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_op_e;
endpackage

// File: rtl/shift_amt_dec.sv
module shift_amt_dec #(
  parameter int AREG_W = 32,
  parameter int AMT_W  = 8,
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int CL_W  = SH_W + 1
) (
  input  logic [AREG_W-1:0] amount_i,
  output logic              zero_o,
  output logic              big_o,   // amount strictly above DATA_W
  output logic [CL_W-1:0]   sat_o,   // min(amount, DATA_W)
  output logic [SH_W-1:0]   rot_o    // amount mod DATA_W
);
  logic [AMT_W-1:0] amt;

  assign amt    = amount_i[AMT_W-1:0];
  assign zero_o = (amt == '0);
  assign big_o  = (amt > AMT_W'(DATA_W));
  assign sat_o  = (amt >= AMT_W'(DATA_W)) ? CL_W'(DATA_W) : CL_W'(amt);
  assign rot_o  = amt[SH_W-1:0];
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int CL_W  = SH_W + 1
) (
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              carry_i,
  input  logic              zero_i,
  input  logic              big_i,
  input  logic [CL_W-1:0]   sat_i,
  input  logic [SH_W-1:0]   rot_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  // Extended-width shifts put the last bit shifted out in the extra bit.
  logic [DATA_W:0]     lsl_ext, lsr_ext, asr_ext;
  logic [2*DATA_W-1:0] ror_dbl;
  logic [DATA_W-1:0]   ror_res;

  assign lsl_ext = {1'b0, operand_i} << sat_i;
  assign lsr_ext = {operand_i, 1'b0} >> sat_i;
  assign asr_ext = $signed({operand_i, 1'b0}) >>> sat_i;
  assign ror_dbl = {operand_i, operand_i} >> rot_i;
  assign ror_res = ror_dbl[DATA_W-1:0];

  always_comb begin
    result_o = operand_i;
    carry_o  = carry_i;
    if (!zero_i) begin
      unique case (shift_op_e'(op_i))
        SH_LSL: begin
          result_o = big_i ? '0 : lsl_ext[DATA_W-1:0];
          carry_o  = big_i ? 1'b0 : lsl_ext[DATA_W];
        end
        SH_LSR: begin
          result_o = big_i ? '0 : lsr_ext[DATA_W:1];
          carry_o  = big_i ? 1'b0 : lsr_ext[0];
        end
        SH_ASR: begin
          result_o = asr_ext[DATA_W:1];
          carry_o  = asr_ext[0];
        end
        default: begin
          // The MSB after rotation is the last bit rotated out; also covers r = 0.
          result_o = ror_res;
          carry_o  = ror_res[DATA_W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/reg_shift_carry.sv
module reg_shift_carry
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AREG_W = 32,
  parameter int AMT_W  = 8,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int CL_W  = SH_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [AREG_W-1:0] amount_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              valid_o
);
  logic            zero, big;
  logic [CL_W-1:0] sat;
  logic [SH_W-1:0] rot;
  logic [DATA_W-1:0] res_d;
  logic              cy_d;

  shift_amt_dec #(.AREG_W(AREG_W), .AMT_W(AMT_W), .DATA_W(DATA_W)) u_dec (
    .amount_i(amount_i), .zero_o(zero), .big_o(big), .sat_o(sat), .rot_o(rot)
  );

  shift_core #(.DATA_W(DATA_W)) u_core (
    .op_i(op_i), .operand_i(operand_i), .carry_i(carry_i),
    .zero_i(zero), .big_i(big), .sat_i(sat), .rot_i(rot),
    .result_o(res_d), .carry_o(cy_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        carry_o  <= cy_d;
      end
    end
  end

  logic [AMT_W-1:0] amt_p;
  assign amt_p = amount_i[AMT_W-1:0];

  assert_valid_lat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(carry_o)));
  assert_zero_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && amt_p == '0) |=> (result_o == $past(operand_i) && carry_o == $past(carry_i)));
  assert_lsl_big_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == SH_LSL && amt_p > AMT_W'(DATA_W)) |=> (result_o == '0 && !carry_o));
  assert_asr_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == SH_ASR && amt_p >= AMT_W'(DATA_W)) |=>
      (result_o == ($past(operand_i[DATA_W-1]) ? {DATA_W{1'b1}} : {DATA_W{1'b0}})
       && carry_o == $past(operand_i[DATA_W-1])));
  assert_ror_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == SH_ROR && amt_p != '0 && amt_p[SH_W-1:0] == '0) |=>
      (result_o == $past(operand_i) && carry_o == $past(operand_i[DATA_W-1])));
endmodule

// File: tb/reg_shift_carry_tb.sv
module reg_shift_carry_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [31:0] operand_i = '0;
  logic [31:0] amount_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  reg_shift_carry u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .operand_i(operand_i), .amount_i(amount_i), .carry_i(carry_i),
    .result_o(result_o), .carry_o(carry_o), .valid_o(valid_o)
  );

  // {op, amount, operand, carry_in, exp_result, exp_carry}
  localparam int NV = 21;
  localparam logic [99:0] VEC [NV] = '{
    {2'd0, 32'h0000_0004, 32'h1234_5678, 1'b0, 32'h2345_6780, 1'b1}, // R3 n=4
    {2'd0, 32'h0000_0020, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1}, // R3 n=32
    {2'd0, 32'h0000_0021, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0}, // R3 n=33
    {2'd0, 32'h0000_0001, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1}, // R3 n=1
    {2'd1, 32'h0000_0001, 32'h0000_0003, 1'b0, 32'h0000_0001, 1'b1}, // R4 n=1
    {2'd1, 32'h0000_0020, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1}, // R4 n=32
    {2'd1, 32'h0000_00C8, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0}, // R4 n=200
    {2'd1, 32'h0000_001F, 32'h4000_0000, 1'b1, 32'h0000_0000, 1'b1}, // R4 n=31
    {2'd2, 32'h0000_0004, 32'h8000_00F0, 1'b0, 32'hF800_000F, 1'b0}, // R5 n=4
    {2'd2, 32'h0000_0028, 32'h8000_0000, 1'b0, 32'hFFFF_FFFF, 1'b1}, // R5 n=40
    {2'd2, 32'h0000_0020, 32'h7FFF_FFFF, 1'b1, 32'h0000_0000, 1'b0}, // R5 n=32
    {2'd3, 32'h0000_0008, 32'h1234_5678, 1'b0, 32'h7812_3456, 1'b0}, // R6 r=8
    {2'd3, 32'h0000_0040, 32'h8000_0000, 1'b0, 32'h8000_0000, 1'b1}, // R6 n=64
    {2'd3, 32'h0000_0021, 32'h0000_0003, 1'b0, 32'h8000_0001, 1'b1}, // R6 n=33
    {2'd3, 32'h0000_0020, 32'h0000_0001, 1'b1, 32'h0000_0001, 1'b0}, // R6 n=32
    {2'd0, 32'h0000_0000, 32'hDEAD_BEEF, 1'b1, 32'hDEAD_BEEF, 1'b1}, // R2 lsl
    {2'd2, 32'h0000_0000, 32'h8000_0000, 1'b0, 32'h8000_0000, 1'b0}, // R2 asr
    {2'd3, 32'h0000_0000, 32'h0000_0005, 1'b1, 32'h0000_0005, 1'b1}, // R2 ror
    {2'd0, 32'hFFFF_FF04, 32'h1234_5678, 1'b0, 32'h2345_6780, 1'b1}, // R1 upper junk
    {2'd3, 32'h0000_0100, 32'h0000_0001, 1'b1, 32'h0000_0001, 1'b1}, // R1 low byte zero
    {2'd1, 32'hABCD_0001, 32'h0000_0003, 1'b0, 32'h0000_0001, 1'b1}  // R1 upper junk
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [31:0] amt,
                       input logic [31:0] a, input logic cin);
    @(negedge clk_i);
    op_i = op; amount_i = amt; operand_i = a; carry_i = cin; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check("R9 valid", {31'd0, valid_o}, 32'd0);
    check("R9 carry", {31'd0, carry_o}, 32'd0);
    check("R9 result", result_o, 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][99:98], VEC[i][97:66], VEC[i][65:34], VEC[i][33]);
      check($sformatf("vec%0d result", i), result_o, VEC[i][32:1]);
      check($sformatf("vec%0d carry", i), {31'd0, carry_o}, {31'd0, VEC[i][0]});
      check($sformatf("vec%0d R7 valid", i), {31'd0, valid_o}, 32'd1);
    end

    // R7: strobe drops the cycle after valid_i drops
    @(negedge clk_i);
    check("R7 valid low", {31'd0, valid_o}, 32'd0);

    // R8: inputs wiggle with valid_i low; outputs hold the last vector's values
    drive(2'd2, 32'h28, 32'h8000_0000, 1'b0);
    op_i = 2'd0; amount_i = 32'h0; operand_i = 32'h1111_1111; carry_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R8 result hold", result_o, 32'hFFFF_FFFF);
    check("R8 carry hold", {31'd0, carry_o}, 32'd1);
    check("R8 valid low", {31'd0, valid_o}, 32'd0);

    // R2: zero amount on logical right returns incoming carry 0 over a set MSB
    drive(2'd1, 32'h0, 32'h8000_0001, 1'b0);
    check("R2 lsr zero result", result_o, 32'h8000_0001);
    check("R2 lsr zero carry", {31'd0, carry_o}, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule